// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block steps a small non-pipelined accumulator machine through its instruction cycle. Every instruction is fetched, can take an extra indirect-address cycle, and is then executed. At the end of each instruction an interrupt cycle runs if a request is pending and interrupts are enabled. A single memory port carries every access. A read or write strobe is held with a stable address until the memory answers with a ready pulse, so the port tolerates any memory latency.

The block holds a program counter, a memory address register, a memory buffer register, an instruction register, an accumulator and an interrupt-enable flag. A controller produces the load enables and strobes that move data among these registers.

Instruction word, 16 bits: bits [15:13] hold the opcode, bit 12 is the indirect flag and bits [11:0] hold the address field. The opcodes are 0 load, 1 add, 2 and, 3 store, 4 jump, 5 enable interrupts, 6 return from interrupt and 7 no operation. The effective address (EA) is the address field, zero-extended. When the indirect flag is set on a load, add, and, store or jump, the EA is instead the full word read from the field's address. The handler vector is 0x0100 and the PC save slot is 0x00FF.

Top module: `instr_cycle_ctl`

## Requirements
- R1: While reset is held low, PC and ACC read zero, the interrupt-enable flag is clear, and neither memory strobe is active.
- R2: The first memory access after reset is a read at address 0. Each fetch reads the word at PC and advances PC by one, so straight-line code runs in address order.
- R3: While `mem_rdy` is low, an active `mem_rd` or `mem_wr` stays active and `mem_addr` stays unchanged on the next cycle.
- R4: `mem_rd` and `mem_wr` are never active in the same cycle.
- R5: Opcodes 0, 1 and 2 set ACC to M[EA], ACC+M[EA] and ACC&M[EA] respectively. Opcode 3 writes ACC to M[EA].
- R6: With bit 12 set, the operand address is the word stored at the address field, not the field itself.
- R7: Opcode 4 loads PC with the EA, direct or indirect.
- R8: When an instruction ends with `irq` high and interrupts enabled, `int_ack` pulses for one cycle and the enable flag clears. The next cycle writes PC to 0x00FF, and PC then becomes 0x0100.
- R9: With the enable flag clear, `irq` has no effect: no `int_ack`, no write to 0x00FF, and program flow is unchanged.
- R10: Opcode 5 sets the enable flag. Opcode 6 reloads PC from M[0x00FF] and sets the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request, level |
| mem_rdata | input | 16 | Read data from memory, valid with `mem_rdy` |
| mem_rdy | input | 1 | Memory completes the current access |
| mem_addr | output | 16 | Memory address (address register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (ACC, or PC in the interrupt cycle) |
| int_ack | output | 1 | One-cycle pulse when the interrupt cycle starts |
| acc_out | output | 16 | Accumulator value |
| pc_out | output | 16 | Program counter value |
| ie_out | output | 1 | Interrupt-enable flag |

## Verification
The hardest case to reach from the ports is a full round trip of an interrupt: the request must meet the enable flag at an instruction boundary, the saved PC must land in the save slot while memory stalls at random, and the return must restore both the PC and the flag. The bench uses short directed programs that enable interrupts and then spin in a self-jump, so the saved PC value is known in advance. It then raises the request a second time to show that re-entry works after the return. Random straight-line programs with mixed direct and indirect operands, run with random memory wait states, are compared against an instruction-level model kept in the bench.

// File: rtl/icc_pkg.sv
package icc_pkg;
   typedef enum logic [2:0] {
      OP_LDA = 3'd0, OP_ADD = 3'd1, OP_AND = 3'd2, OP_STA = 3'd3,
      OP_JMP = 3'd4, OP_ENI = 3'd5, OP_RET = 3'd6, OP_NOP = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      CL_LOAD, CL_STORE, CL_JUMP, CL_ENA, CL_RET, CL_IDLE
   } cls_e;

   typedef enum logic [1:0] {MA_PC, MA_FLD, MA_MBR, MA_SAVE} mar_e;
   typedef enum logic [1:0] {PS_INC, PS_FLD, PS_MBR, PS_VEC} pcs_e;

   typedef struct packed {
      logic ld_mar;
      mar_e mar_src;
      logic ld_mbr;
      logic ld_ir;
      logic ld_pc;
      pcs_e pc_src;
      logic ld_acc;
      logic ie_set;
      logic ie_clr;
      logic wsel_pc;
      logic mem_rd;
      logic mem_wr;
      logic int_ack;
   } ctl_t;
endpackage

// File: rtl/icc_ctrl.sv
module icc_ctrl
   import icc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ind_i,
   input  cls_e cls_i,
   input  logic irq_i,
   input  logic ie_i,
   input  logic rdy_i,
   output ctl_t ctl_o
);
   typedef enum logic [3:0] {
      S_FA, S_FR, S_FI, S_DEC, S_IA, S_IR, S_XA, S_XR,
      S_XALU, S_XRET, S_XW, S_XJ, S_XOP, S_CHK, S_INTA, S_INTW
   } st_e;

   st_e  st, nxt;
   ctl_t c;
   logic uses_ea;

   assign uses_ea = (cls_i == CL_LOAD) || (cls_i == CL_STORE) || (cls_i == CL_JUMP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= S_FA;
      else        st <= nxt;
   end

   always_comb begin
      c   = '0;
      nxt = st;
      case (st)
         S_FA: begin
            c.ld_mar  = 1'b1;
            c.mar_src = MA_PC;
            nxt       = S_FR;
         end
         S_FR: begin
            c.mem_rd = 1'b1;
            if (rdy_i) begin
               c.ld_mbr = 1'b1;
               c.ld_pc  = 1'b1;
               c.pc_src = PS_INC;
               nxt      = S_FI;
            end
         end
         S_FI: begin
            c.ld_ir = 1'b1;
            nxt     = S_DEC;
         end
         S_DEC: begin
            if (ind_i && uses_ea) nxt = S_IA;
            else begin
               case (cls_i)
                  CL_LOAD, CL_STORE, CL_RET: nxt = S_XA;
                  CL_JUMP:                   nxt = S_XJ;
                  default:                   nxt = S_XOP;
               endcase
            end
         end
         S_IA: begin
            c.ld_mar  = 1'b1;
            c.mar_src = MA_FLD;
            nxt       = S_IR;
         end
         S_IR: begin
            c.mem_rd = 1'b1;
            if (rdy_i) begin
               c.ld_mbr = 1'b1;
               nxt      = (cls_i == CL_JUMP) ? S_XJ : S_XA;
            end
         end
         S_XA: begin
            c.ld_mar = 1'b1;
            if (cls_i == CL_RET) c.mar_src = MA_SAVE;
            else                 c.mar_src = ind_i ? MA_MBR : MA_FLD;
            nxt = (cls_i == CL_STORE) ? S_XW : S_XR;
         end
         S_XR: begin
            c.mem_rd = 1'b1;
            if (rdy_i) begin
               c.ld_mbr = 1'b1;
               nxt      = (cls_i == CL_RET) ? S_XRET : S_XALU;
            end
         end
         S_XALU: begin
            c.ld_acc = 1'b1;
            nxt      = S_CHK;
         end
         S_XRET: begin
            c.ld_pc  = 1'b1;
            c.pc_src = PS_MBR;
            c.ie_set = 1'b1;
            nxt      = S_CHK;
         end
         S_XW: begin
            c.mem_wr = 1'b1;
            if (rdy_i) nxt = S_CHK;
         end
         S_XJ: begin
            c.ld_pc  = 1'b1;
            c.pc_src = ind_i ? PS_MBR : PS_FLD;
            nxt      = S_CHK;
         end
         S_XOP: begin
            c.ie_set = (cls_i == CL_ENA);
            nxt      = S_CHK;
         end
         S_CHK: nxt = (irq_i && ie_i) ? S_INTA : S_FA;
         S_INTA: begin
            c.ld_mar  = 1'b1;
            c.mar_src = MA_SAVE;
            c.int_ack = 1'b1;
            c.ie_clr  = 1'b1;
            nxt       = S_INTW;
         end
         S_INTW: begin
            c.mem_wr  = 1'b1;
            c.wsel_pc = 1'b1;
            if (rdy_i) begin
               c.ld_pc  = 1'b1;
               c.pc_src = PS_VEC;
               nxt      = S_FA;
            end
         end
         default: nxt = S_FA;
      endcase
   end

   assign ctl_o = c;

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_o.mem_rd && ctl_o.mem_wr));
   assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o.mem_rd && !rdy_i) |=> ctl_o.mem_rd);
   assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o.mem_wr && !rdy_i) |=> ctl_o.mem_wr);
endmodule

// File: rtl/icc_dpath.sv
module icc_dpath
   import icc_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 16,
   parameter int FLD_W     = 12,
   parameter int VEC_ADDR  = 16'h0100,
   parameter int SAVE_ADDR = 16'h00FF
)(
   input  logic          clk,
   input  logic          rst_n,
   input  ctl_t          ctl_i,
   input  logic          rdy_i,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          ind_o,
   output cls_e          cls_o,
   output logic          ie_o,
   output logic [DW-1:0] acc_o,
   output logic [AW-1:0] pc_o
);
   localparam int OPW   = 3;
   localparam int IND_B = DW - OPW - 1;
   localparam logic [AW-1:0] VEC  = AW'(VEC_ADDR);
   localparam logic [AW-1:0] SAVE = AW'(SAVE_ADDR);

   if (AW > DW) begin : g_bad_aw
      $error("address width exceeds data width");
   end
   if (FLD_W > IND_B || FLD_W > AW) begin : g_bad_fld
      $error("address field does not fit");
   end

   logic [AW-1:0] pc, mar, fld_ext, mbr_addr;
   logic [DW-1:0] mbr, ir, acc, pc_word;
   logic          ie;
   op_e           op;

   if (AW > FLD_W) begin : g_fld_ext
      assign fld_ext = {{(AW-FLD_W){1'b0}}, mbr[FLD_W-1:0]};
   end else begin : g_fld_full
      assign fld_ext = mbr[FLD_W-1:0];
   end

   if (DW > AW) begin : g_pc_ext
      assign pc_word = {{(DW-AW){1'b0}}, pc};
   end else begin : g_pc_full
      assign pc_word = pc;
   end

   assign mbr_addr = mbr[AW-1:0];
   assign op       = op_e'(ir[DW-1 -: OPW]);
   assign ind_o    = ir[IND_B];

   always_comb begin
      case (op)
         OP_LDA, OP_ADD, OP_AND: cls_o = CL_LOAD;
         OP_STA:                 cls_o = CL_STORE;
         OP_JMP:                 cls_o = CL_JUMP;
         OP_ENI:                 cls_o = CL_ENA;
         OP_RET:                 cls_o = CL_RET;
         default:                cls_o = CL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc  <= '0;
         mar <= '0;
         mbr <= '0;
         ir  <= '0;
         acc <= '0;
         ie  <= 1'b0;
      end else begin
         if (ctl_i.ld_mar) begin
            case (ctl_i.mar_src)
               MA_PC:   mar <= pc;
               MA_FLD:  mar <= fld_ext;
               MA_MBR:  mar <= mbr_addr;
               default: mar <= SAVE;
            endcase
         end
         if (ctl_i.ld_mbr) mbr <= mem_rdata;
         if (ctl_i.ld_ir)  ir  <= mbr;
         if (ctl_i.ld_pc) begin
            case (ctl_i.pc_src)
               PS_INC:  pc <= pc + AW'(1);
               PS_FLD:  pc <= fld_ext;
               PS_MBR:  pc <= mbr_addr;
               default: pc <= VEC;
            endcase
         end
         if (ctl_i.ld_acc) begin
            case (op)
               OP_LDA:  acc <= mbr;
               OP_ADD:  acc <= acc + mbr;
               OP_AND:  acc <= acc & mbr;
               default: acc <= acc;
            endcase
         end
         if (ctl_i.ie_clr)      ie <= 1'b0;
         else if (ctl_i.ie_set) ie <= 1'b1;
      end
   end

   assign mem_addr  = mar;
   assign mem_wdata = ctl_i.wsel_pc ? pc_word : acc;
   assign ie_o      = ie;
   assign acc_o     = acc;
   assign pc_o      = pc;

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_i.mem_rd || ctl_i.mem_wr) && !rdy_i) |=> $stable(mar));
   assert_ack_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.int_ack |=> (ctl_i.mem_wr && ctl_i.wsel_pc && mar == SAVE && !ie));
   assert_ack_ie_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.int_ack |-> ie);
endmodule

// File: rtl/instr_cycle_ctl.sv
module instr_cycle_ctl
   import icc_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 16,
   parameter int FLD_W     = 12,
   parameter int VEC_ADDR  = 16'h0100,
   parameter int SAVE_ADDR = 16'h00FF
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_rdy,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   output logic          int_ack,
   output logic [DW-1:0] acc_out,
   output logic [AW-1:0] pc_out,
   output logic          ie_out
);
   ctl_t ctl;
   logic ind;
   cls_e cls;
   logic ie;

   icc_ctrl u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .ind_i (ind),
      .cls_i (cls),
      .irq_i (irq),
      .ie_i  (ie),
      .rdy_i (mem_rdy),
      .ctl_o (ctl)
   );

   icc_dpath #(
      .DW(DW), .AW(AW), .FLD_W(FLD_W),
      .VEC_ADDR(VEC_ADDR), .SAVE_ADDR(SAVE_ADDR)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_i     (ctl),
      .rdy_i     (mem_rdy),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .ind_o     (ind),
      .cls_o     (cls),
      .ie_o      (ie),
      .acc_o     (acc_out),
      .pc_o      (pc_out)
   );

   assign mem_rd  = ctl.mem_rd;
   assign mem_wr  = ctl.mem_wr;
   assign int_ack = ctl.int_ack;
   assign ie_out  = ie;
endmodule

// File: tb/sim_instr_cycle_ctl.sv
module sim_instr_cycle_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        mem_rdy = 1'b0;
   logic [15:0] mem_addr, mem_wdata, acc_out, pc_out;
   logic        mem_rd, mem_wr, int_ack, ie_out;

   instr_cycle_ctl u0 (
      .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .int_ack(int_ack), .acc_out(acc_out), .pc_out(pc_out), .ie_out(ie_out)
   );

   always #2 clk = ~clk;

   logic [15:0] mem [0:4095];
   logic [15:0] mdl [0:4095];
   int nchk = 0, nbad = 0, acks = 0, v3 = 0, v4 = 0, wcnt = 0;
   bit prv_req = 0, done = 0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] enc(int op, int ind, int fld);
      return {op[2:0], ind[0], fld[11:0]};
   endfunction

   // memory model with random wait states, plus port monitors
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rdy = 1'b0;
         prv_req = 0;
      end else begin
         if (mem_rd && mem_wr) v4++;
         if (prv_req && !(mem_rd || mem_wr)) v3++;
         if (int_ack) begin
            acks++;
            irq = 1'b0;
         end
         if (mem_rdy) mem_rdy = 1'b0;
         else if (mem_rd || mem_wr) begin
            if (wcnt == 0) begin
               if (mem_wr) mem[mem_addr[11:0]] = mem_wdata;
               else        mem_rdata = mem[mem_addr[11:0]];
               mem_rdy = 1'b1;
               wcnt = $urandom % 4;
            end else wcnt--;
         end
         prv_req = (mem_rd || mem_wr) && !mem_rdy;
      end
   end

   task automatic hold_reset();
      @(negedge clk);
      rst_n = 1'b0;
      irq   = 1'b0;
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      @(negedge clk);
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic iss(output logic [15:0] acc);
      logic [15:0] ins, ea;
      acc = '0;
      for (int i = 0; i < 16; i++) begin
         ins = mdl[i];
         ea  = {4'h0, ins[11:0]};
         if (ins[12]) ea = mdl[ea[11:0]];
         case (ins[15:13])
            3'd0: acc = mdl[ea[11:0]];
            3'd1: acc = acc + mdl[ea[11:0]];
            3'd2: acc = acc & mdl[ea[11:0]];
            3'd3: mdl[ea[11:0]] = acc;
            default: ;
         endcase
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      logic [15:0] eacc;
      int mism;
      void'($urandom(32'h5eed_1c0d));

      // R1: reset state
      hold_reset();
      chk(pc_out == 0, "R1", "pc in reset", pc_out, 0);
      chk(acc_out == 0, "R1", "acc in reset", acc_out, 0);
      chk(ie_out == 0, "R1", "ie in reset", ie_out, 0);
      chk(!mem_rd && !mem_wr, "R1", "strobes in reset", {mem_rd, mem_wr}, 0);

      // R2 R5 R6: random straight-line programs vs instruction model
      for (int r = 0; r < 6; r++) begin
         hold_reset();
         for (int k = 0; k < 32; k++) begin
            mem[12'h200 + k] = 16'($urandom);
            mem[12'h300 + k] = 16'h0200 + 16'($urandom % 32);
         end
         for (int i = 0; i < 16; i++) begin
            int op, ind, k;
            op  = $urandom % 4;
            ind = $urandom % 2;
            k   = $urandom % 32;
            mem[i] = enc(op, ind, ind ? (12'h300 + k) : (12'h200 + k));
         end
         mem[16] = enc(4, 0, 16);
         for (int i = 0; i < 4096; i++) mdl[i] = mem[i];
         iss(eacc);
         rst_n = 1'b1;
         if (r == 0) begin
            while (!mem_rd) @(negedge clk);
            chk(mem_addr == 0, "R2", "first fetch address", mem_addr, 0);
         end
         wait_cyc(900);
         chk(acc_out == eacc, "R5", "acc after program", acc_out, eacc);
         mism = 0;
         for (int k = 0; k < 32; k++)
            if (mem[12'h200 + k] !== mdl[12'h200 + k]) mism++;
         chk(mism == 0, "R6", "data words after stores", mism, 0);
         chk(pc_out == 16 || pc_out == 17, "R2", "pc at end loop", pc_out, 16);
      end

      // R7 R6: indirect jump then direct load
      hold_reset();
      mem[0]       = enc(4, 1, 12'h040);
      mem[12'h040] = 16'h0123;
      mem[12'h123] = enc(0, 0, 12'h041);
      mem[12'h041] = 16'h5A5A;
      mem[12'h124] = enc(4, 0, 12'h124);
      rst_n = 1'b1;
      wait_cyc(300);
      chk(acc_out == 16'h5A5A, "R7", "acc after indirect jump", acc_out, 16'h5A5A);
      chk(pc_out == 16'h124 || pc_out == 16'h125, "R7", "pc in target loop", pc_out, 16'h124);

      // R9: request ignored while disabled
      hold_reset();
      mem[0]       = enc(4, 0, 0);
      mem[12'h0FF] = 16'hDEAD;
      acks = 0;
      rst_n = 1'b1;
      irq = 1'b1;
      wait_cyc(300);
      chk(acks == 0, "R9", "no ack while disabled", acks, 0);
      chk(mem[12'h0FF] == 16'hDEAD, "R9", "save slot untouched", mem[12'h0FF], 16'hDEAD);
      chk(pc_out <= 1, "R9", "pc stays in loop", pc_out, 0);
      chk(ie_out == 0, "R9", "ie stays clear", ie_out, 0);

      // R8 R10: enable, take interrupt, handler, return, re-enter
      hold_reset();
      mem[0]       = enc(5, 0, 0);
      mem[1]       = enc(4, 0, 1);
      mem[12'h050] = 16'd7;
      mem[12'h100] = enc(1, 0, 12'h050);
      mem[12'h101] = enc(6, 0, 0);
      acks = 0;
      rst_n = 1'b1;
      irq = 1'b1;
      while (acks == 0) @(negedge clk);
      chk(ie_out == 0, "R8", "ie cleared on entry", ie_out, 0);
      wait_cyc(400);
      chk(acks == 1, "R8", "one ack", acks, 1);
      chk(mem[12'h0FF] == 16'd1, "R8", "saved pc", mem[12'h0FF], 1);
      chk(acc_out == 16'd7, "R8", "handler ran", acc_out, 7);
      chk(ie_out == 1, "R10", "ie set after return", ie_out, 1);
      chk(pc_out == 1 || pc_out == 2, "R10", "pc back in loop", pc_out, 1);
      irq = 1'b1;
      wait_cyc(400);
      chk(acks == 2, "R8", "second ack", acks, 2);
      chk(acc_out == 16'd14, "R10", "handler ran twice", acc_out, 14);
      chk(ie_out == 1, "R10", "ie set after second return", ie_out, 1);

      chk(v3 == 0, "R3", "strobe dropped before ready", v3, 0);
      chk(v4 == 0, "R4", "read and write together", v4, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule